// File: doc/BRIEF.md
# Idle-Time Driven Per-Engine Voltage/Frequency Governor

This block chooses the operating point of one multithreaded processing engine from how much of the engine's time is lost waiting on memory. A cycle is idle only when every hardware thread of the engine reports that it is blocked on an outstanding memory access. A cycle where any thread can run is busy, and that includes a thread that is only polling buffers or status registers.

The governor works in observation windows whose length is picked from three programmable values. At the end of each window it compares the share of idle cycles with a fixed percentage threshold. If the engine was idle more often than the threshold, the level drops one step. If it was idle less often, the level rises one step. An exact tie keeps the level. The level never goes past either end of the table.

A level change is followed by a settling stall of a fixed number of cycles. During the stall, idle cycles are not counted. A fresh window starts when the stall ends. One instance serves one engine, and no instance shares state with another. The level table has five points, from 400 MHz at 1100 mV up to 600 MHz at 1300 mV, in steps of 50 MHz and 50 mV.

Top module: `engine_idle_dvfs`

## Requirements
- R1: After a synchronous active-low reset, `level` is 4 (the top of the table), `stall` is 0, `freq_mhz` is 600 and `vdd_mv` is 1300.
- R2: A cycle counts as idle only when all `thread_wait` bits are 1. If any bit is 0, the cycle counts as busy.
- R3: The window length is taken from `win_sel` on the first cycle of each window. Code 0 selects WIN_LEN0, 1 selects WIN_LEN1, 2 selects WIN_LEN2, and 3 selects WIN_LEN0. A change of `win_sel` later in the same window has no effect until the next window.
- R4: On the last cycle of a window, let idle be the idle count and len the window length. If idle×100 > IDLE_PCT×len, the level goes down by one. If idle×100 < IDLE_PCT×len, the level goes up by one. If the two are equal, the level holds. The default IDLE_PCT is 10.
- R5: At level 0 a step down is not taken, and at level 4 a step up is not taken. In both cases no stall follows.
- R6: Whenever the level changes, `stall` is 1 from the first cycle the new level is visible and stays 1 for exactly PENALTY_CYCLES cycles (default 6000). The level is constant while `stall` is 1.
- R7: Idle cycles during a stall are not counted. The next window begins on the first cycle after `stall` returns to 0. When no change occurs, the next window begins on the cycle right after the window's last cycle.
- R8: `freq_mhz` equals 400 + 50×`level`, and `vdd_mv` equals 1100 + 50×`level`.
- R9: The level never moves by more than one step between consecutive cycles and never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| thread_wait | input | N_THREADS | One bit per thread; 1 = blocked on a memory access |
| win_sel | input | 2 | Window length code, sampled at window start |
| level | output | 3 | Current operating-point index, 0 = slowest |
| stall | output | 1 | Transition settling in progress |
| freq_mhz | output | 10 | Clock frequency of the current level in MHz |
| vdd_mv | output | 11 | Supply voltage of the current level in mV |

## Verification
The assertions check the following on every cycle:
- the level stays inside the table and moves by at most one step;
- every level change raises the stall;
- the level stays constant while the stall is high;
- each stall lasts exactly the penalty length.

Other behaviours need scenarios from the bench. The bench drives window patterns with chosen idle counts to show:
- the down/up/hold decision with the strict-inequality tie rule;
- clamping at both ends of the table;
- the window-length codes and the rule that `win_sel` is sampled only at window start;
- that polling cycles with some threads running count as busy.

Directed runs show that idle cycles during the stall are discarded and that a reset in the middle of a stall returns the block to the top level.

// File: rtl/edvfs_pkg.sv
// Package: shared constants and types for the per-engine idle-time governor.
// Assumes a five-point operating table with uniform frequency and voltage steps.
package edvfs_pkg;
    localparam int FREQ_BASE_MHZ = 400;
    localparam int FREQ_STEP_MHZ = 50;
    localparam int VDD_BASE_MV   = 1100;
    localparam int VDD_STEP_MV   = 50;
    localparam int PCT_SCALE     = 100;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_t;
endpackage

// File: rtl/edvfs_idle_detect.sv
// Idle detector: flags a cycle as idle when every thread is blocked on memory.
// Assumes thread_wait is already synchronous to clk.
module edvfs_idle_detect #(
    parameter int N_THREADS = 4
) (
    input  logic [N_THREADS-1:0] thread_wait,
    output logic                 idle
);
    logic [N_THREADS:0] chain;

    // Purpose: AND chain over all thread wait flags.
    assign chain[0] = 1'b1;
    for (genvar t = 0; t < N_THREADS; t++) begin : g_chain
        assign chain[t+1] = chain[t] & thread_wait[t];
    end
    assign idle = chain[N_THREADS];
endmodule

// File: rtl/edvfs_window_accum.sv
// Window accumulator: counts window cycles and idle cycles while run is high.
// The window length is latched from win_sel on the first cycle of each window.
// Assumes every programmed length is at least 1 and fits CNT_W bits.
module edvfs_window_accum #(
    parameter int WIN_LEN0 = 20000,
    parameter int WIN_LEN1 = 40000,
    parameter int WIN_LEN2 = 60000,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             idle,
    input  logic [1:0]       win_sel,
    output logic             win_end,
    output logic [CNT_W-1:0] idle_total,
    output logic [CNT_W-1:0] len_total
);
    logic [CNT_W-1:0] win_cnt;
    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W-1:0] cur_len;
    logic [CNT_W-1:0] sel_len;
    logic             first_cyc;

    // Purpose: decode the window length code (3 aliases the shortest).
    always_comb begin
        case (win_sel)
            2'd1:    sel_len = CNT_W'(WIN_LEN1);
            2'd2:    sel_len = CNT_W'(WIN_LEN2);
            default: sel_len = CNT_W'(WIN_LEN0);
        endcase
    end

    // Purpose: pick the live length, fresh on the first cycle, latched after.
    assign first_cyc  = (win_cnt == '0);
    assign len_total  = first_cyc ? sel_len : cur_len;
    assign win_end    = run && (win_cnt == len_total - CNT_W'(1));
    assign idle_total = idle_cnt + CNT_W'(idle);

    // Purpose: advance the window and idle counters, clear between windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            idle_cnt <= '0;
        end else if (!run || win_end) begin
            win_cnt  <= '0;
            idle_cnt <= '0;
        end else begin
            win_cnt  <= win_cnt + CNT_W'(1);
            idle_cnt <= idle_total;
        end
    end

    // Purpose: hold the length chosen on the first cycle for the whole window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_len <= CNT_W'(WIN_LEN0);
        end else if (run && first_cyc) begin
            cur_len <= sel_len;
        end
    end
endmodule

// File: rtl/edvfs_level_decide.sv
// Level decision: compares idle*100 with pct*len without division and
// proposes the next level, clamped to the table bounds.
// Assumes IDLE_PCT is between 0 and 100.
module edvfs_level_decide
    import edvfs_pkg::*;
#(
    parameter int N_LEVELS = 5,
    parameter int IDLE_PCT = 10,
    parameter int CNT_W    = 16,
    parameter int LVL_W    = 3
) (
    input  logic [CNT_W-1:0] idle_total,
    input  logic [CNT_W-1:0] len_total,
    input  logic [LVL_W-1:0] cur_level,
    output logic [LVL_W-1:0] next_level,
    output logic             changed
);
    localparam int PROD_W = CNT_W + 8;
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(N_LEVELS - 1);

    logic [PROD_W-1:0] idle_scaled;
    logic [PROD_W-1:0] thresh_scaled;
    step_t             step;

    // Purpose: scale both sides so the percentage compare needs no divider.
    assign idle_scaled   = PROD_W'(idle_total) * PROD_W'(PCT_SCALE);
    assign thresh_scaled = PROD_W'(IDLE_PCT) * PROD_W'(len_total);

    // Purpose: choose the step direction; an exact tie holds.
    always_comb begin
        if (idle_scaled > thresh_scaled)      step = STEP_DOWN;
        else if (idle_scaled < thresh_scaled) step = STEP_UP;
        else                                  step = STEP_HOLD;
    end

    // Purpose: apply the step inside the table bounds.
    always_comb begin
        next_level = cur_level;
        case (step)
            STEP_DOWN: if (cur_level != '0)     next_level = cur_level - LVL_W'(1);
            STEP_UP:   if (cur_level != TOP_LVL) next_level = cur_level + LVL_W'(1);
            default:   next_level = cur_level;
        endcase
    end
    assign changed = (next_level != cur_level);
endmodule

// File: rtl/edvfs_settle_timer.sv
// Settle timer: holds busy high for exactly PENALTY_CYCLES cycles after start.
// Assumes PENALTY_CYCLES >= 1 and that start never arrives while busy.
module edvfs_settle_timer #(
    parameter int PENALTY_CYCLES = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int PEN_W = $clog2(PENALTY_CYCLES + 1);

    logic [PEN_W-1:0] remain;

    // Purpose: load and count down the settling interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= PEN_W'(PENALTY_CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - PEN_W'(1);
        end
    end
endmodule

// File: rtl/engine_idle_dvfs.sv
// Top: idle-time driven voltage/frequency governor for one processing engine.
// Counts all-threads-blocked cycles per window, steps the level by one at the
// window end, and stalls for a fixed penalty after every change.
// Assumes one instance per engine; instances share nothing.
module engine_idle_dvfs
    import edvfs_pkg::*;
#(
    parameter int N_THREADS      = 4,
    parameter int N_LEVELS       = 5,
    parameter int IDLE_PCT       = 10,
    parameter int WIN_LEN0       = 20000,
    parameter int WIN_LEN1       = 40000,
    parameter int WIN_LEN2       = 60000,
    parameter int PENALTY_CYCLES = 6000,
    parameter int LVL_W          = $clog2(N_LEVELS),
    parameter int FREQ_W         = 10,
    parameter int VDD_W          = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_THREADS-1:0] thread_wait,
    input  logic [1:0]           win_sel,
    output logic [LVL_W-1:0]     level,
    output logic                 stall,
    output logic [FREQ_W-1:0]    freq_mhz,
    output logic [VDD_W-1:0]     vdd_mv
);
    localparam int LEN_MAX01 = (WIN_LEN0 > WIN_LEN1) ? WIN_LEN0 : WIN_LEN1;
    localparam int LEN_MAX   = (LEN_MAX01 > WIN_LEN2) ? LEN_MAX01 : WIN_LEN2;
    localparam int CNT_W     = $clog2(LEN_MAX + 1);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(N_LEVELS - 1);

    logic             idle;
    logic             win_end;
    logic [CNT_W-1:0] idle_total;
    logic [CNT_W-1:0] len_total;
    logic [LVL_W-1:0] next_level;
    logic             changed;
    logic             settle_busy;
    logic             take_step;

    edvfs_idle_detect #(.N_THREADS(N_THREADS)) idle_i (
        .thread_wait (thread_wait),
        .idle        (idle)
    );

    edvfs_window_accum #(
        .WIN_LEN0 (WIN_LEN0),
        .WIN_LEN1 (WIN_LEN1),
        .WIN_LEN2 (WIN_LEN2),
        .CNT_W    (CNT_W)
    ) accum_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (!settle_busy),
        .idle       (idle),
        .win_sel    (win_sel),
        .win_end    (win_end),
        .idle_total (idle_total),
        .len_total  (len_total)
    );

    edvfs_level_decide #(
        .N_LEVELS (N_LEVELS),
        .IDLE_PCT (IDLE_PCT),
        .CNT_W    (CNT_W),
        .LVL_W    (LVL_W)
    ) decide_i (
        .idle_total (idle_total),
        .len_total  (len_total),
        .cur_level  (level),
        .next_level (next_level),
        .changed    (changed)
    );

    assign take_step = win_end && changed;

    edvfs_settle_timer #(.PENALTY_CYCLES(PENALTY_CYCLES)) settle_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (take_step),
        .busy  (settle_busy)
    );

    // Purpose: hold the operating level, updated only at a deciding window end.
    always_ff @(posedge clk) begin
        if (!rst_n)         level <= TOP_LVL;
        else if (take_step) level <= next_level;
    end

    // Purpose: drive the stall and the operating point of the current level.
    assign stall    = settle_busy;
    assign freq_mhz = FREQ_W'(FREQ_BASE_MHZ) + FREQ_W'(FREQ_STEP_MHZ) * FREQ_W'(level);
    assign vdd_mv   = VDD_W'(VDD_BASE_MV) + VDD_W'(VDD_STEP_MV) * VDD_W'(level);
endmodule

// File: rtl/edvfs_checker.sv
// Checker: temporal properties of the level and stall outputs of the governor.
// Assumes it is bound to engine_idle_dvfs and sees its outputs only.
module edvfs_checker #(
    parameter int N_LEVELS       = 5,
    parameter int PENALTY_CYCLES = 6000,
    parameter int LVL_W          = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] level,
    input logic             stall
);
    localparam int RUN_W = $clog2(PENALTY_CYCLES + 1) + 1;

    logic             past_ok;
    logic [RUN_W-1:0] stall_run;

    // Purpose: mark cycles whose previous sample lies after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Purpose: count consecutive stall cycles for the penalty length check.
    always_ff @(posedge clk) begin
        if (!rst_n)     stall_run <= '0;
        else if (stall) stall_run <= stall_run + RUN_W'(1);
        else            stall_run <= '0;
    end

    // R9: level inside the table
    a_r9_level_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(N_LEVELS - 1));

    // R9: at most one step per cycle
    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (level != $past(level)) |->
            ((level == LVL_W'($past(level) + 1'b1)) || (level == LVL_W'($past(level) - 1'b1))));

    // R6: every level change raises the stall
    a_r6_change_stalls: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (level != $past(level)) |-> stall);

    // R6: level frozen while stalled
    a_r6_level_frozen: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (stall && $past(stall)) |-> $stable(level));

    // R6: stall never outlasts the penalty
    a_r6_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (stall_run < RUN_W'(PENALTY_CYCLES)));

    // R6: a completed stall lasted exactly the penalty
    a_r6_stall_exact: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $fell(stall) |-> (stall_run == RUN_W'(PENALTY_CYCLES)));
endmodule

bind engine_idle_dvfs edvfs_checker #(
    .N_LEVELS       (N_LEVELS),
    .PENALTY_CYCLES (PENALTY_CYCLES),
    .LVL_W          (LVL_W)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .level (level),
    .stall (stall)
);

// File: tb/engine_idle_dvfs_tb_top.sv
// Bench: vector table of windows with chosen idle counts, then directed tests.
module engine_idle_dvfs_tb_top;
    localparam int NT   = 4;
    localparam int L0   = 100;
    localparam int L1   = 200;
    localparam int L2   = 300;
    localparam int PEN  = 20;
    localparam int NVEC = 13;

    // Per vector: window code, idle cycles in the window, expected level after.
    localparam int V_SEL [NVEC] = '{0, 0, 0, 1, 2, 2, 0, 1, 0, 0, 3, 0, 0};
    localparam int V_IDLE[NVEC] = '{10, 0, 50, 21, 30, 31, 100, 19, 100, 100, 9, 11, 0};
    localparam int V_LVL [NVEC] = '{4, 4, 3, 2, 2, 1, 0, 1, 0, 0, 1, 0, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] thread_wait = '0;
    logic [1:0]    win_sel = 2'd0;
    logic [2:0]    level;
    logic          stall;
    logic [9:0]    freq_mhz;
    logic [10:0]   vdd_mv;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    engine_idle_dvfs #(
        .N_THREADS      (NT),
        .WIN_LEN0       (L0),
        .WIN_LEN1       (L1),
        .WIN_LEN2       (L2),
        .PENALTY_CYCLES (PEN)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .thread_wait (thread_wait),
        .win_sel     (win_sel),
        .level       (level),
        .stall       (stall),
        .freq_mhz    (freq_mhz),
        .vdd_mv      (vdd_mv)
    );

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sel_len(input int s);
        return (s == 1) ? L1 : (s == 2) ? L2 : L0;
    endfunction

    // R2: busy polling cycles keep all threads but one waiting
    function automatic logic [NT-1:0] busy_pattern(input int i);
        return ~(NT'(1) << (i % NT));
    endfunction

    // Drive one window from a negedge; returns at the negedge after its last edge.
    task automatic drive_window(input int sel, input int idle_n, input int mid_sel);
        int len = sel_len(sel);
        win_sel = 2'(sel);
        for (int i = 0; i < len; i++) begin
            if (i == 5 && mid_sel >= 0) win_sel = 2'(mid_sel);
            thread_wait = (i < idle_n) ? '1 : busy_pattern(i);
            @(negedge clk);
        end
        thread_wait = '1;
    endtask

    // Check level, stall and operating point after a window; ride out a stall.
    task automatic after_window(input string tag, input int exp_lvl, input int prev_lvl);
        bit chg = (exp_lvl != prev_lvl);
        check({tag, " level"}, int'(level), exp_lvl);
        check({tag, " R6 stall raised"}, int'(stall), int'(chg));
        check({tag, " R8 freq"}, int'(freq_mhz), 400 + 50 * exp_lvl);
        check({tag, " R8 vdd"}, int'(vdd_mv), 1100 + 50 * exp_lvl);
        if (chg) begin
            repeat (PEN - 1) @(negedge clk);
            check({tag, " R6 stall last cycle"}, int'(stall), 1);
            @(negedge clk);
            check({tag, " R6 R7 stall dropped"}, int'(stall), 0);
            check({tag, " R6 level held"}, int'(level), exp_lvl);
        end
    endtask

    initial begin
        int prev;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check("R1 level in reset", int'(level), 4);
        check("R1 stall in reset", int'(stall), 0);
        rst_n = 1'b1;
        check("R1 freq", int'(freq_mhz), 600);
        check("R1 vdd", int'(vdd_mv), 1300);

        // R2 R3 R4 R5 R7: table walk; vector 7 (index 7) follows a stall
        // spent all-idle, so counting it would flip the expected step
        prev = 4;
        for (int v = 0; v < NVEC; v++) begin
            drive_window(V_SEL[v], V_IDLE[v], -1);
            after_window($sformatf("R2/R3/R4/R5/R7 vec%0d", v), V_LVL[v], prev);
            prev = V_LVL[v];
        end

        // R3: win_sel moved to the longest code mid-window is ignored
        drive_window(0, 0, 2);
        after_window("R3 mid-window select", 2, 1);

        // R4: tie on the longest window holds the level, no stall
        drive_window(2, 30, -1);
        after_window("R4 tie long window", 2, 2);

        // R1: reset in the middle of a stall
        drive_window(0, 40, -1);
        check("R4 down before reset", int'(level), 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 level after mid-stall reset", int'(level), 4);
        check("R1 stall after mid-stall reset", int'(stall), 0);

        // R5: top bound with a fully busy window
        drive_window(1, 0, -1);
        after_window("R5 top bound", 4, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule